// File: doc/BRIEF.md
# PC Card Host Window Decoder

This block holds the eight host address windows of a PC Card socket controller and decodes every host access against them. Software programs each window through a small write-only register port: a base address and an option word that carries a size code, the space type (common memory, attribute memory or I/O), the socket, the port width, write protection and a valid flag. There is no offset register. The card address is the part of the host address below the window size.

For each access presented with `acc_valid`, the block compares the address against all eight windows in parallel. When more than one window matches, the lowest-numbered window wins. One cycle later the block reports whether the access hit a window, which window it was, and that window's attributes. It also says whether the access may be passed on to the card-side logic. A write that lands in a write-protected window is not passed on. Instead it raises a one-cycle error flag. Strobe timing and the card bus protocol are handled elsewhere.

Top module: `pcw_window_decoder`

## Requirements
- R1: Register address `2*n` writes the base of window n and `2*n+1` writes its option word. A write changes the decode of any access presented in the following cycle or later.
- R2: A window matches when the address bits at and above the window size equal the same bits of its base. Base bits below the size are ignored.
- R3: Option bits 31:27 hold the size code. Codes 0..15 give 1, 2, 8, 4, 128, 64, 16, 32 B, 32K, 16K, 4K, 8K, 256, 512, 2K, 1K B. Codes 20, 21 and 23 give 16M, 32M and 64M. Codes 24..31 give 64K, 128K, 512K, 256K, 8M, 4M, 1M and 2M.
- R4: Size codes 16, 17, 18, 19 and 22 are invalid, and a window that holds one of them never matches.
- R5: A window whose option bit 0 (valid) is clear never matches.
- R6: When several windows match, `dec_win` reports the lowest-numbered one.
- R7: On a hit, the outputs copy the winning window's option fields: `dec_space` from bits 4:3 (00 common, 10 attribute, 11 I/O), `dec_sock_b` from bit 2, `dec_wide` from bit 6 and `dec_wprot` from bit 1.
- R8: A write access that hits a write-protected window sets `dec_wp_err` for one cycle and leaves `dec_fwd` low. Every other hit sets `dec_fwd`.
- R9: When an access misses, or `acc_valid` is low, all decode outputs are zero in the result cycle.
- R10: Results appear one clock after the access is presented. A synchronous active-low reset clears every window register and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: window index times two, plus 1 for the option word |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Host access present |
| acc_addr | input | 32 | Host access address |
| acc_write | input | 1 | Host access is a write |
| dec_hit | output | 1 | Access matched a window |
| dec_win | output | 3 | Index of the winning window |
| dec_sock_b | output | 1 | Winning window targets socket B |
| dec_space | output | 2 | Space type of the winning window |
| dec_wide | output | 1 | Winning window uses a 16-bit port |
| dec_wprot | output | 1 | Winning window is write-protected |
| dec_fwd | output | 1 | Access may be forwarded to the card |
| dec_wp_err | output | 1 | Write to a protected window was blocked |

## Verification
The bench builds the block with its default parameters: eight windows and a 32-bit address. With these values, the largest 64 MB size code and the smallest 1-byte code can both be programmed on real windows. The stimulus places one small window inside a larger one to exercise the priority order. It also probes one address on each side of a window edge, chosen so that the neighbouring size in the scrambled code order would give a different answer. One window carries an invalid code and another has its valid bit clear, and both are checked as never matching.

// File: rtl/pcw_pkg.sv
// Shared definitions for the PC Card window decoder.
// Assumes option words are 32 bits with fixed field positions.
package pcw_pkg;

    localparam int OPT_W = 32;

    // Option fields kept per window (unused option bits are not stored).
    typedef struct packed {
        logic [4:0] size_code;
        logic       wide;
        logic [1:0] space;
        logic       sock_b;
        logic       wprot;
        logic       valid;
    } opt_t;

    // Unpack a written option word into its stored fields.
    function automatic opt_t opt_unpack(input logic [OPT_W-1:0] w);
        opt_t o;
        o.size_code = w[31:27];
        o.wide      = w[6];
        o.space     = w[4:3];
        o.sock_b    = w[2];
        o.wprot     = w[1];
        o.valid     = w[0];
        return o;
    endfunction

    // Map a size code to {legal, log2(bytes)}.
    function automatic logic [5:0] size_lookup(input logic [4:0] code);
        logic [5:0] r;
        case (code)
            5'd0:  r = {1'b1, 5'd0};
            5'd1:  r = {1'b1, 5'd1};
            5'd2:  r = {1'b1, 5'd3};
            5'd3:  r = {1'b1, 5'd2};
            5'd4:  r = {1'b1, 5'd7};
            5'd5:  r = {1'b1, 5'd6};
            5'd6:  r = {1'b1, 5'd4};
            5'd7:  r = {1'b1, 5'd5};
            5'd8:  r = {1'b1, 5'd15};
            5'd9:  r = {1'b1, 5'd14};
            5'd10: r = {1'b1, 5'd12};
            5'd11: r = {1'b1, 5'd13};
            5'd12: r = {1'b1, 5'd8};
            5'd13: r = {1'b1, 5'd9};
            5'd14: r = {1'b1, 5'd11};
            5'd15: r = {1'b1, 5'd10};
            5'd20: r = {1'b1, 5'd24};
            5'd21: r = {1'b1, 5'd25};
            5'd23: r = {1'b1, 5'd26};
            5'd24: r = {1'b1, 5'd16};
            5'd25: r = {1'b1, 5'd17};
            5'd26: r = {1'b1, 5'd19};
            5'd27: r = {1'b1, 5'd18};
            5'd28: r = {1'b1, 5'd23};
            5'd29: r = {1'b1, 5'd22};
            5'd30: r = {1'b1, 5'd20};
            5'd31: r = {1'b1, 5'd21};
            default: r = {1'b0, 5'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcw_size_decode.sv
// Turns a size code into a compare mask covering the address bits
// at and above the window size. Assumes ADDR_W > 26.
module pcw_size_decode #(
    parameter int ADDR_W = 32
) (
    input  logic [4:0]        code,
    output logic              legal,
    output logic [ADDR_W-1:0] mask
);
    logic [4:0] lg;

    // Look up size and build the upper-bit mask.
    always_comb begin
        {legal, lg} = pcw_pkg::size_lookup(code);
        mask        = {ADDR_W{1'b1}} << lg;
    end
endmodule

// File: rtl/pcw_window_match.sv
// Compares one host address against one window.
// Assumes the window fields are stable during the compare.
module pcw_window_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  pcw_pkg::opt_t     opt,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);
    logic              legal;
    logic [ADDR_W-1:0] mask;

    pcw_size_decode #(.ADDR_W(ADDR_W)) u_size (
        .code  (opt.size_code),
        .legal (legal),
        .mask  (mask)
    );

    // Match on the masked upper bits of a valid, legally sized window.
    always_comb match = opt.valid && legal && (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/pcw_prio_pick.sv
// Chooses the lowest-numbered set request bit.
// Assumes IDX_W is wide enough to index N.
module pcw_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is the final assignment.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pcw_window_decoder.sv
// Bank of host windows for a PC Card socket controller. Holds base and
// option registers for every window, decodes each host access against
// them and registers the result for one cycle. Assumes ADDR_W <= 32.
module pcw_window_decoder #(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int CFG_AW = IDX_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [pcw_pkg::OPT_W-1:0] cfg_wdata,
    input  logic                      acc_valid,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic                      acc_write,
    output logic                      dec_hit,
    output logic [IDX_W-1:0]          dec_win,
    output logic                      dec_sock_b,
    output logic [1:0]                dec_space,
    output logic                      dec_wide,
    output logic                      dec_wprot,
    output logic                      dec_fwd,
    output logic                      dec_wp_err
);
    logic [ADDR_W-1:0] base_q [NUM_WIN];
    pcw_pkg::opt_t     opt_q  [NUM_WIN];
    logic [NUM_WIN-1:0] match;
    logic               any;
    logic [IDX_W-1:0]   pick;
    pcw_pkg::opt_t      sel;
    logic               take;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        // Window registers: even address is base, odd is option.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[w] <= '0;
                opt_q[w]  <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(2 * w)) begin
                base_q[w] <= cfg_wdata[ADDR_W-1:0];
            end else if (cfg_we && cfg_addr == CFG_AW'(2 * w + 1)) begin
                opt_q[w]  <= pcw_pkg::opt_unpack(cfg_wdata);
            end
        end

        pcw_window_match #(.ADDR_W(ADDR_W)) u_match (
            .base  (base_q[w]),
            .opt   (opt_q[w]),
            .addr  (acc_addr),
            .match (match[w])
        );
    end

    pcw_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .req (match),
        .any (any),
        .idx (pick)
    );

    // Select the winning window's fields and qualify by access valid.
    always_comb begin
        sel  = opt_q[pick];
        take = acc_valid && any;
    end

    // Register the decode result.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            dec_hit    <= 1'b0;
            dec_win    <= '0;
            dec_sock_b <= 1'b0;
            dec_space  <= 2'b00;
            dec_wide   <= 1'b0;
            dec_wprot  <= 1'b0;
            dec_fwd    <= 1'b0;
            dec_wp_err <= 1'b0;
        end else begin
            dec_hit    <= 1'b1;
            dec_win    <= pick;
            dec_sock_b <= sel.sock_b;
            dec_space  <= sel.space;
            dec_wide   <= sel.wide;
            dec_wprot  <= sel.wprot;
            dec_fwd    <= !(acc_write && sel.wprot);
            dec_wp_err <= acc_write && sel.wprot;
        end
    end
endmodule

// File: rtl/pcw_window_decoder_chk.sv
// Assertion checker for the window decoder, attached by bind.
// Assumes one-cycle result latency.
module pcw_window_decoder_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             dec_hit,
    input logic [IDX_W-1:0] dec_win,
    input logic [1:0]       dec_space,
    input logic             dec_wprot,
    input logic             dec_fwd,
    input logic             dec_wp_err
);
    a_r8_err_blocks_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wp_err |-> (!dec_fwd && dec_wprot && dec_hit));

    a_r8_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wp_err |-> $past(acc_write));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> (!dec_hit && !dec_fwd && !dec_wp_err));

    a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_win == '0 && dec_space == 2'b00 && !dec_wprot && !dec_fwd));

    a_r8_hit_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (dec_fwd != dec_wp_err));
endmodule

bind pcw_window_decoder pcw_window_decoder_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .dec_hit    (dec_hit),
    .dec_win    (dec_win),
    .dec_space  (dec_space),
    .dec_wprot  (dec_wprot),
    .dec_fwd    (dec_fwd),
    .dec_wp_err (dec_wp_err)
);

// File: tb/pcw_window_decoder_tb.sv
`timescale 1ns/1ps
module pcw_window_decoder_tb;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        dec_hit, dec_sock_b, dec_wide, dec_wprot, dec_fwd, dec_wp_err;
    logic [2:0]  dec_win;
    logic [1:0]  dec_space;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcw_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .dec_hit(dec_hit), .dec_win(dec_win),
        .dec_sock_b(dec_sock_b), .dec_space(dec_space), .dec_wide(dec_wide),
        .dec_wprot(dec_wprot), .dec_fwd(dec_fwd), .dec_wp_err(dec_wp_err)
    );

    // Result word: {hit, win[2:0], space[1:0], wide, sock_b, wprot, fwd, err}
    function automatic logic [11:0] observed();
        return {dec_hit, dec_win, dec_space, dec_wide, dec_sock_b, dec_wprot, dec_fwd, dec_wp_err};
    endfunction

    // Vector: {addr[31:0], write, expected result[11:0]}
    localparam logic [44:0] VEC [NV] = '{
        {32'h1000_7FFF, 1'b0, 12'b1_000_00_0_0_0_1_0}, // R3 32K edge, R6 W0 over W3
        {32'h1000_8000, 1'b0, 12'b1_011_00_0_0_0_1_0}, // R2 outside W0, inside W3
        {32'h2345_6789, 1'b0, 12'b1_001_10_1_0_0_1_0}, // R7 attribute, 16-bit
        {32'h3000_0000, 1'b0, 12'b1_010_11_0_1_1_1_0}, // R7 I/O, socket B, read of wp
        {32'h3000_0001, 1'b0, 12'b0_000_00_0_0_0_0_0}, // R3 1-byte window edge
        {32'h3000_0000, 1'b1, 12'b1_010_11_0_1_1_0_1}, // R8 write to wp
        {32'h5000_0000, 1'b0, 12'b0_000_00_0_0_0_0_0}, // R4 invalid code
        {32'h6000_0000, 1'b0, 12'b0_000_00_0_0_0_0_0}, // R5 not valid
        {32'h7000_00FF, 1'b1, 12'b1_110_00_0_0_1_0_1}, // R8 write to wp
        {32'h7000_0100, 1'b0, 12'b0_000_00_0_0_0_0_0}, // R3 256-byte edge
        {32'h1000_0000, 1'b1, 12'b1_000_00_0_0_0_1_0}, // R8 unprotected write
        {32'h7000_0000, 1'b0, 12'b1_110_00_0_0_1_1_0}, // R2 base low bits ignored
        {32'h8007_FFFF, 1'b0, 12'b1_111_00_0_0_0_1_0}, // R3 code 26 is 512K
        {32'h8008_0000, 1'b0, 12'b0_000_00_0_0_0_0_0}, // R3 512K edge
        {32'h2400_0000, 1'b0, 12'b0_000_00_0_0_0_0_0}  // R9 just past 64M
    };

    task automatic check(input string req, input logic [11:0] exp);
        checks++;
        if (observed() !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", req, observed(), exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one access for one cycle; sample at the following negedge.
    task automatic access(input logic v, input logic [31:0] a, input logic w);
        acc_valid = v; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset outputs", 12'b0);
        rst_n = 1'b1;
        // R1 register layout: base at 2n, option at 2n+1
        cfg_write(4'd0,  32'h1000_0000); cfg_write(4'd1,  32'h4000_0001);
        cfg_write(4'd2,  32'h2000_0000); cfg_write(4'd3,  32'hB800_0051);
        cfg_write(4'd4,  32'h3000_0000); cfg_write(4'd5,  32'h0000_001F);
        cfg_write(4'd6,  32'h1000_0000); cfg_write(4'd7,  32'hB800_0001);
        cfg_write(4'd8,  32'h5000_0000); cfg_write(4'd9,  32'h8000_0001);
        cfg_write(4'd10, 32'h6000_0000); cfg_write(4'd11, 32'h1800_0000);
        cfg_write(4'd12, 32'h7000_0042); cfg_write(4'd13, 32'h6000_0003);
        cfg_write(4'd14, 32'h8000_0000); cfg_write(4'd15, 32'hD000_0001);

        for (int i = 0; i < NV; i++) begin
            access(1'b1, VEC[i][44:13], VEC[i][12]);
            check($sformatf("R2 R3 R6 R7 R8 vector %0d", i), VEC[i][11:0]);
        end

        // R9: matching address with acc_valid low
        access(1'b0, 32'h1000_0000, 1'b1);
        check("R9 idle access", 12'b0);

        // R5 and R1: clear window 0 option, next access falls to window 3
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_we = 1'b0;
        access(1'b1, 32'h1000_0000, 1'b0);
        check("R5 R1 cleared window 0", 12'b1_011_00_0_0_0_1_0);

        // R1: rewrite window 5 as valid, 4-byte I/O; decode right after
        cfg_write(4'd11, 32'h1800_0019);
        access(1'b1, 32'h6000_0003, 1'b0);
        check("R1 new window 5", 12'b1_101_11_0_0_0_1_0);

        // R10: reset clears window registers
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 outputs after reset", 12'b0);
        access(1'b1, 32'h1000_0000, 1'b0);
        check("R10 windows cleared", 12'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule